// File: doc/BRIEF.md
# Byte Write Enable Generator

This block turns the attributes of one bus write into four active-low byte-lane write strobes for a 32-bit data bus. The lanes are numbered in big-endian order, so lane 0 is the most significant byte. It uses five inputs:

- the transfer size;
- the two low address bits;
- the port width of the selected memory region;
- the burst-capable flag of that region;
- a qualifier that marks an active write cycle.

The port width and the burst flag come from a separate chip-select unit.

Memories narrower than 32 bits are wired to the upper lanes of the bus. For those regions the strobes follow the port width as well as the size and the address. A 16-bit region only ever sees lanes 0 and 1, and an 8-bit region only ever sees lane 0. The strobes are registered, so each decoded result appears one clock after its inputs are sampled. The block does not sequence multi-cycle transfers to narrow ports, match addresses or generate addresses.

Top module: `byte_write_strobe_gen`

## Requirements
- R1: While `rst` is high, and on the first clock edge with it high, all four strobes `we_n` become 1 (inactive).
- R2: When `xfer_active` is 0 or `xfer_write` is 0 at a clock edge, all four strobes are 1 after that edge.
- R3: Strobes are registered: inputs sampled at one rising edge determine `we_n` from that edge until the next. `we_n[0]` gates data bits 31:24, `we_n[1]` bits 23:16, `we_n[2]` bits 15:8 and `we_n[3]` bits 7:0.
- R4: Size codes on `xfer_size` are 2'b01 byte, 2'b10 word, 2'b00 longword and 2'b11 line. On a 32-bit port (`port_width` 2'b00) a byte write at `addr_lo` = n drives only `we_n[n]` low.
- R5: On a 32-bit port a word write drives `we_n[1:0]` low when `addr_lo[1]` is 0, and `we_n[3:2]` low when it is 1.
- R6: On a 32-bit port a longword or line write drives all four strobes low.
- R7: On a 16-bit port (`port_width` 2'b10) a byte write drives `we_n[0]` low when `addr_lo[0]` is 0 and `we_n[1]` low when it is 1. `we_n[3:2]` stay 1.
- R8: On a 16-bit port a word, longword or line write drives `we_n[1:0]` low and leaves `we_n[3:2]` at 1.
- R9: On an 8-bit port (`port_width` 2'b01) every write drives only `we_n[0]` low.
- R10: The value of `burst_ok` never changes `we_n`. Line writes decode as longwords whether or not the region can burst.
- R11: The unused port code 2'b11 decodes exactly as a 32-bit port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| xfer_active | input | 1 | A bus transfer is in progress |
| xfer_write | input | 1 | 1 for a write, 0 for a read |
| xfer_size | input | 2 | Transfer size code |
| addr_lo | input | 2 | Address bits 1:0 |
| port_width | input | 2 | Port width of the selected region |
| burst_ok | input | 1 | Selected region accepts bursts |
| we_n | output | 4 | Active-low byte-lane write strobes, index 0 = bits 31:24 |

## Verification
Some properties are checked on every cycle after reset:

- Idle and read cycles leave every strobe high.
- A write always lowers at least one strobe.
- A byte write lowers exactly one strobe.
- A 16-bit region never touches the lower two lanes.
- An 8-bit region only ever uses lane 0.
- A line write to a 32-bit region lowers all four strobes even without burst capability.

Other behaviour can only be shown by the bench's scenarios. These are the exact lane chosen for each address offset, the split of word writes by address bit 1, and the treatment of the spare port code as 32-bit. The one-cycle latency and the lack of any effect from `burst_ok` also need the bench, since they must be compared across consecutive, chosen stimuli.

// File: rtl/bwe_pkg.sv
package bwe_pkg;

    localparam int unsigned LANES    = 4;
    localparam int unsigned SIZE_W   = 2;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned PORT_W   = 2;

    typedef enum logic [SIZE_W-1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef enum logic [PORT_W-1:0] {
        PW_32    = 2'b00,
        PW_8     = 2'b01,
        PW_16    = 2'b10,
        PW_SPARE = 2'b11
    } port_width_e;

    typedef struct packed {
        logic              active;
        logic              write;
        xfer_size_e        size;
        logic [ADDR_W-1:0] addr;
        port_width_e       port;
    } wr_req_t;

    typedef logic [LANES-1:0] lane_mask_t;

    // Line transfers take the same lanes as a longword.
    function automatic xfer_size_e fold_size(xfer_size_e s);
        return (s == SZ_LINE) ? SZ_LONG : s;
    endfunction

    // Lanes a 32-bit region uses; bit i set means lane i is written.
    function automatic lane_mask_t mask_full(xfer_size_e s, logic [ADDR_W-1:0] a);
        lane_mask_t m;
        unique case (fold_size(s))
            SZ_BYTE: m = lane_mask_t'(1) << a;
            SZ_WORD: m = a[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    // Lanes a 16-bit region uses: only the upper two lanes of the bus.
    function automatic lane_mask_t mask_half(xfer_size_e s, logic [ADDR_W-1:0] a);
        lane_mask_t m;
        if (fold_size(s) == SZ_BYTE) m = a[0] ? 4'b0010 : 4'b0001;
        else                         m = 4'b0011;
        return m;
    endfunction

    // The spare port code decodes as a 32-bit region.
    function automatic lane_mask_t lane_mask(wr_req_t r);
        lane_mask_t m;
        unique case (r.port)
            PW_8:    m = 4'b0001;
            PW_16:   m = mask_half(r.size, r.addr);
            default: m = mask_full(r.size, r.addr);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bwe_lane_decode.sv
module bwe_lane_decode
    import bwe_pkg::*;
(
    input  wr_req_t          req,
    output logic [LANES-1:0] strobe_n
);
    lane_mask_t mask;
    logic       qual;

    always_comb begin
        mask = lane_mask(req);
        qual = req.active & req.write;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb strobe_n[g] = ~(qual & mask[g]);
    end

    always_comb begin
        if (req.port == PW_8)
            assert (strobe_n[LANES-1:1] == '1) else $error("AST_NARROW8_LANE0 violated"); // R9
        if (req.port == PW_16)
            assert (strobe_n[3:2] == 2'b11) else $error("AST_HALF_UPPER violated"); // R8
    end
endmodule

// File: rtl/bwe_strobe_reg.sv
module bwe_strobe_reg #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_n,
    output logic [WIDTH-1:0] q_n
);
    always_ff @(posedge clk) begin
        if (rst) q_n <= '1;
        else     q_n <= d_n;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> q_n == '1) else $error("AST_RESET_IDLE"); // R1
endmodule

// File: rtl/byte_write_strobe_gen.sv
module byte_write_strobe_gen
    import bwe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_active,
    input  logic       xfer_write,
    input  logic [1:0] xfer_size,
    input  logic [1:0] addr_lo,
    input  logic [1:0] port_width,
    input  logic       burst_ok,
    output logic [3:0] we_n
);
    wr_req_t          req;
    logic [LANES-1:0] next_n;

    always_comb begin
        req.active = xfer_active;
        req.write  = xfer_write;
        req.size   = xfer_size_e'(xfer_size);
        req.addr   = addr_lo;
        req.port   = port_width_e'(port_width);
    end

    bwe_lane_decode u_decode (
        .req      (req),
        .strobe_n (next_n)
    );

    bwe_strobe_reg #(.WIDTH(LANES)) u_reg (
        .clk (clk),
        .rst (rst),
        .d_n (next_n),
        .q_n (we_n)
    );

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !(xfer_active && xfer_write) |=> we_n == 4'hF) else $error("AST_IDLE_HIGH"); // R2
    AST_WRITE_SOME: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && xfer_write) |=> we_n != 4'hF) else $error("AST_WRITE_SOME"); // R3
    AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && xfer_write && xfer_size == 2'b01) |=> $countones(~we_n) == 1)
        else $error("AST_BYTE_SINGLE"); // R4
    AST_LINE_NOBURST: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && xfer_write && xfer_size == 2'b11 && port_width == 2'b00 && !burst_ok)
        |=> we_n == 4'h0) else $error("AST_LINE_NOBURST"); // R10
    AST_NARROW8: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && xfer_write && port_width == 2'b01) |=> we_n == 4'b1110)
        else $error("AST_NARROW8"); // R9
endmodule

// File: tb/tb_byte_write_strobe_gen.sv
module tb_byte_write_strobe_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic       xfer_active, xfer_write, burst_ok;
    logic [1:0] xfer_size, addr_lo, port_width;
    logic [3:0] we_n;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    byte_write_strobe_gen dut (
        .clk(clk), .rst(rst), .xfer_active(xfer_active), .xfer_write(xfer_write),
        .xfer_size(xfer_size), .addr_lo(addr_lo), .port_width(port_width),
        .burst_ok(burst_ok), .we_n(we_n)
    );

    // {act, wr, size, addr, port, burst, expected we_n, req number}
    typedef struct packed {
        logic       act;
        logic       wr;
        logic [1:0] sz;
        logic [1:0] ad;
        logic [1:0] pw;
        logic       bu;
        logic [3:0] exp_n;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1,1,2'b01,2'd0,2'b00,0,4'b1110,4'd4},  // R4 byte lane 0
        '{1,1,2'b01,2'd1,2'b00,0,4'b1101,4'd4},  // R4 byte lane 1
        '{1,1,2'b01,2'd2,2'b00,1,4'b1011,4'd4},  // R4 byte lane 2
        '{1,1,2'b01,2'd3,2'b00,0,4'b0111,4'd4},  // R4 byte lane 3
        '{1,1,2'b10,2'd0,2'b00,0,4'b1100,4'd5},  // R5 word upper
        '{1,1,2'b10,2'd2,2'b00,0,4'b0011,4'd5},  // R5 word lower
        '{1,1,2'b10,2'd3,2'b00,1,4'b0011,4'd5},  // R5 word lower, a0 ignored
        '{1,1,2'b00,2'd0,2'b00,0,4'b0000,4'd6},  // R6 longword
        '{1,1,2'b11,2'd0,2'b00,1,4'b0000,4'd6},  // R6 line, burst
        '{1,1,2'b11,2'd0,2'b00,0,4'b0000,4'd10}, // R10 line, no burst
        '{1,1,2'b01,2'd0,2'b10,0,4'b1110,4'd7},  // R7 half byte even
        '{1,1,2'b01,2'd1,2'b10,0,4'b1101,4'd7},  // R7 half byte odd
        '{1,1,2'b01,2'd3,2'b10,1,4'b1101,4'd7},  // R7 half byte odd high addr
        '{1,1,2'b10,2'd2,2'b10,0,4'b1100,4'd8},  // R8 half word
        '{1,1,2'b00,2'd0,2'b10,0,4'b1100,4'd8},  // R8 half long
        '{1,1,2'b11,2'd0,2'b10,1,4'b1100,4'd8},  // R8 half line
        '{1,1,2'b01,2'd3,2'b01,0,4'b1110,4'd9},  // R9 narrow byte
        '{1,1,2'b10,2'd2,2'b01,0,4'b1110,4'd9},  // R9 narrow word
        '{1,1,2'b00,2'd0,2'b01,1,4'b1110,4'd9},  // R9 narrow long
        '{1,1,2'b01,2'd2,2'b11,0,4'b1011,4'd11}, // R11 spare byte
        '{1,1,2'b10,2'd2,2'b11,0,4'b0011,4'd11}, // R11 spare word
        '{1,1,2'b00,2'd0,2'b11,0,4'b0000,4'd11}, // R11 spare long
        '{1,0,2'b00,2'd0,2'b00,0,4'b1111,4'd2},  // R2 read
        '{0,1,2'b00,2'd0,2'b00,0,4'b1111,4'd2},  // R2 idle
        '{0,0,2'b01,2'd1,2'b10,1,4'b1111,4'd2},  // R2 idle read
        '{1,1,2'b10,2'd0,2'b10,1,4'b1100,4'd3}   // R3 mapping
    };

    task automatic drive(input vec_t v);
        xfer_active = v.act; xfer_write = v.wr; xfer_size = v.sz;
        addr_lo = v.ad; port_width = v.pw; burst_ok = v.bu;
    endtask

    task automatic check(input logic [3:0] exp_n, input int rq, input string what);
        n_run++;
        if (we_n !== exp_n) begin
            n_fail++;
            $display("FAIL R%0d %s: got %b expected %b", rq, what, we_n, exp_n);
        end
    endtask

    task automatic apply(input vec_t v, input string what);
        @(negedge clk); drive(v);
        @(negedge clk); check(v.exp_n, int'(v.rq), what);
    endtask

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        vec_t w;
        rst = 1'b1;
        drive('{1,1,2'b00,2'd0,2'b00,0,4'b0000,4'd1});
        repeat (3) @(negedge clk);
        check(4'hF, 1, "R1 reset holds strobes high during write");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) apply(VECS[i], "table vector");

        // R3: one-cycle latency, strobes follow each edge
        @(negedge clk); drive(VECS[0]);
        @(posedge clk); #1; drive(VECS[3]);
        @(negedge clk); check(4'b1110, 3, "R3 latency first value");
        @(negedge clk); check(4'b0111, 3, "R3 latency second value");

        // R10: toggling burst alone leaves strobes unchanged
        for (int b = 0; b < 2; b++) begin
            w = '{1,1,2'b01,2'd2,2'b00,1'(b),4'b1011,4'd10};
            apply(w, "R10 burst toggle byte");
            w = '{1,1,2'b10,2'd0,2'b10,1'(b),4'b1100,4'd10};
            apply(w, "R10 burst toggle half word");
        end

        // R2: write then read releases strobes on the next edge
        apply(VECS[7], "R6 long before read");
        w = '{1,0,2'b00,2'd0,2'b00,0,4'b1111,4'd2};
        apply(w, "R2 read after write");

        // R1: reset in the middle of a write stream
        @(negedge clk); drive(VECS[7]); rst = 1'b1;
        @(negedge clk); check(4'hF, 1, "R1 reset mid-stream");
        rst = 1'b0;
        @(negedge clk); check(4'h0, 6, "R6 resume after reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule